// File: doc/BRIEF.md
# Aligned Word Load/Store Unit

This unit sits between an execute stage and a word-wide data memory with a combinational read port. Each request carries a base register value, a signed 16-bit displacement, store data, a direction (load or store), an access size and a signedness bit. From these it forms the byte address, checks that the address falls on a four-byte boundary and drives a word address, a write strobe, per-byte lane enables and lane-gated write data toward the memory.

Sub-word accesses never steer lanes from the low address bits. A halfword always lives in the two least-significant bytes of the addressed word, and a byte always lives in the least-significant byte. Because every legal address is word aligned, the low address bits serve only to detect misuse. The extracted load value is extended to a full word and registered. It appears one cycle after the request.

Top module: `word_lsu`

## Requirements
- R1: The byte address is `baseVal` plus `offsetImm` sign-extended to 32 bits. `memAddr` carries byte-address bits 31:2 in the request cycle.
- R2: `misalign` is high in the request cycle exactly when `reqValid` is high and either of the two low byte-address bits is set.
- R3: A misaligned request causes no memory write (`memWe` 0, `memBe` 0000). A misaligned load does not raise `loadValid` and leaves `loadData` unchanged.
- R4: An aligned store (`reqStore`=1) raises `memWe`. `memBe` depends on `reqSize`: 0 (word) gives 1111, 1 (halfword) gives 0011, and 2 (byte) gives 0001. `memWdata` carries `storeData` in enabled lanes and zero in the others.
- R5: A halfword load returns bits 15:0 of the addressed word. The value is zero-extended when `reqUnsigned`=1 and sign-extended from bit 15 otherwise.
- R6: A byte load returns bits 7:0 of the addressed word. The value is zero-extended when `reqUnsigned`=1 and sign-extended from bit 7 otherwise.
- R7: A word load (`reqSize`=0) returns all 32 bits of the addressed word, whatever `reqUnsigned` is.
- R8: `loadValid` is high in exactly the cycle after an aligned load request, and `loadData` then holds the result. In every other cycle `loadData` keeps its last value.
- R9: After reset, `loadValid` and `loadData` are zero.
- R10: `reqSize`=3 behaves as a word access for both loads and stores.
- R11: While `reqValid` is low, `memWe`, `memBe` and `misalign` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 0 word, 1 halfword, 2 byte, 3 treated as word |
| reqUnsigned | input | 1 | Zero-extend sub-word load |
| baseVal | input | 32 | Base register value |
| offsetImm | input | 16 | Signed displacement |
| storeData | input | 32 | Data to store |
| memRdata | input | 32 | Word read from memory at `memAddr` |
| memAddr | output | 30 | Word address |
| memWe | output | 1 | Memory write strobe |
| memBe | output | 4 | Byte lane enables |
| memWdata | output | 32 | Lane-gated write data |
| misalign | output | 1 | Misaligned request flag |
| loadData | output | 32 | Registered extended load result |
| loadValid | output | 1 | Load result valid |

## Verification
The assertions assume that `memRdata` reflects the word at `memAddr` within the request cycle. They also assume that `reqSize`, `reqStore` and `reqUnsigned` stay steady while `reqValid` is high. The extension checks compare the registered result against the previous cycle's request strobes, so they depend on each request being presented for one cycle only. The stimulus follows these rules. It drives each request for a single cycle from the falling edge and then leaves a cycle with no request. It models the memory as a combinational read array indexed by the low word-address bits. It sweeps every low-address pattern, positive and negative displacements, all four size codes and both extension modes.

// File: rtl/word_lsu_pkg.sv
package word_lsu_pkg;
  parameter int unsigned LSU_LANES = 4;
  localparam int unsigned LSU_DATA_W = LSU_LANES * 8;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    EXT_WORD = 2'd0,
    EXT_HALF = 2'd1,
    EXT_BYTE = 2'd2
  } extKind_e;

  typedef struct packed {
    logic                 doWrite;
    logic                 doLoad;
    logic [LSU_LANES-1:0] laneMask;
    extKind_e             extKind;
    logic                 extUnsigned;
  } lsuStrobe_t;
endpackage

// File: rtl/word_lsu_ctrl.sv
module word_lsu_ctrl
  import word_lsu_pkg::*;
(
  input  logic       reqValid,
  input  logic       reqStore,
  input  logic [1:0] reqSize,
  input  logic       reqUnsigned,
  input  logic [1:0] addrLow,
  output lsuStrobe_t strobe,
  output logic       misalign
);
  localparam int unsigned HALF_LANES = 2;

  logic                 aligned;
  logic [LSU_LANES-1:0] sizeMask;

  always_comb begin
    sizeMask = '0;
    for (int l = 0; l < LSU_LANES; l++) begin
      unique case (accSize_e'(reqSize))
        SZ_HALF: sizeMask[l] = (l < HALF_LANES);
        SZ_BYTE: sizeMask[l] = (l == 0);
        default: sizeMask[l] = 1'b1;
      endcase
    end
  end

  always_comb begin
    aligned            = (addrLow == 2'b00);
    misalign           = reqValid && !aligned;
    strobe.doWrite     = reqValid && reqStore && aligned;
    strobe.doLoad      = reqValid && !reqStore && aligned;
    strobe.laneMask    = strobe.doWrite ? sizeMask : '0;
    strobe.extUnsigned = reqUnsigned;
    unique case (accSize_e'(reqSize))
      SZ_HALF: strobe.extKind = EXT_HALF;
      SZ_BYTE: strobe.extKind = EXT_BYTE;
      default: strobe.extKind = EXT_WORD;
    endcase
  end
endmodule

// File: rtl/word_lsu_dp.sv
module word_lsu_dp
  import word_lsu_pkg::*;
#(
  parameter int unsigned OFF_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LSU_DATA_W-1:0] baseVal,
  input  logic [OFF_W-1:0]      offsetImm,
  input  logic [LSU_DATA_W-1:0] storeData,
  input  logic [LSU_DATA_W-1:0] memRdata,
  input  lsuStrobe_t            strobe,
  output logic [LSU_DATA_W-1:0] effAddr,
  output logic [LSU_DATA_W-3:0] memAddr,
  output logic                  memWe,
  output logic [LSU_LANES-1:0]  memBe,
  output logic [LSU_DATA_W-1:0] memWdata,
  output logic [LSU_DATA_W-1:0] loadData,
  output logic                  loadValid
);
  localparam int unsigned HALF_W = 16;
  localparam int unsigned BYTE_W = 8;

  logic [LSU_DATA_W-1:0] offsetExt;
  logic [LSU_DATA_W-1:0] loadNext;

  assign offsetExt = {{(LSU_DATA_W-OFF_W){offsetImm[OFF_W-1]}}, offsetImm};
  assign effAddr   = baseVal + offsetExt;
  assign memAddr   = effAddr[LSU_DATA_W-1:2];
  assign memWe     = strobe.doWrite;
  assign memBe     = strobe.laneMask;

  for (genvar l = 0; l < LSU_LANES; l++) begin : g_lane
    assign memWdata[l*8 +: 8] = strobe.laneMask[l] ? storeData[l*8 +: 8] : 8'h00;
  end

  always_comb begin
    unique case (strobe.extKind)
      EXT_HALF: loadNext = {{(LSU_DATA_W-HALF_W){memRdata[HALF_W-1] & !strobe.extUnsigned}},
                            memRdata[HALF_W-1:0]};
      EXT_BYTE: loadNext = {{(LSU_DATA_W-BYTE_W){memRdata[BYTE_W-1] & !strobe.extUnsigned}},
                            memRdata[BYTE_W-1:0]};
      default:  loadNext = memRdata;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadData  <= '0;
      loadValid <= 1'b0;
    end else begin
      loadValid <= strobe.doLoad;
      if (strobe.doLoad) loadData <= loadNext;
    end
  end

  p_write_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (effAddr[1:0] == 2'b00));

  p_lane_shape_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memBe == 4'b1111 || memBe == 4'b0011 || memBe == 4'b0001));

  p_half_sext_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doLoad && strobe.extKind == EXT_HALF && !strobe.extUnsigned)
      |=> (loadData[LSU_DATA_W-1:HALF_W] == {(LSU_DATA_W-HALF_W){loadData[HALF_W-1]}}));

  p_byte_zext_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doLoad && strobe.extKind == EXT_BYTE && strobe.extUnsigned)
      |=> (loadData[LSU_DATA_W-1:BYTE_W] == '0));

  p_valid_next_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doLoad |=> loadValid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doLoad |=> (!loadValid && $stable(loadData)));
endmodule

// File: rtl/word_lsu.sv
module word_lsu
  import word_lsu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqStore,
  input  logic [1:0]  reqSize,
  input  logic        reqUnsigned,
  input  logic [31:0] baseVal,
  input  logic [15:0] offsetImm,
  input  logic [31:0] storeData,
  input  logic [31:0] memRdata,
  output logic [29:0] memAddr,
  output logic        memWe,
  output logic [3:0]  memBe,
  output logic [31:0] memWdata,
  output logic        misalign,
  output logic [31:0] loadData,
  output logic        loadValid
);
  lsuStrobe_t  strobe;
  logic [31:0] effAddr;

  word_lsu_ctrl u_ctrl (
    .reqValid    (reqValid),
    .reqStore    (reqStore),
    .reqSize     (reqSize),
    .reqUnsigned (reqUnsigned),
    .addrLow     (effAddr[1:0]),
    .strobe      (strobe),
    .misalign    (misalign)
  );

  word_lsu_dp #(.OFF_W(16)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .baseVal   (baseVal),
    .offsetImm (offsetImm),
    .storeData (storeData),
    .memRdata  (memRdata),
    .strobe    (strobe),
    .effAddr   (effAddr),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memBe     (memBe),
    .memWdata  (memWdata),
    .loadData  (loadData),
    .loadValid (loadValid)
  );

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!memWe && memBe == 4'b0000 && !misalign));

  p_misalign_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (!memWe && memBe == 4'b0000));
endmodule

// File: tb/word_lsu_tb.sv
`timescale 1ns/1ps
module word_lsu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqStore = 1'b0, reqUnsigned = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] baseVal = '0, storeData = '0;
  logic [15:0] offsetImm = '0;
  logic [31:0] memRdata;
  logic [29:0] memAddr;
  logic        memWe, misalign, loadValid;
  logic [3:0]  memBe;
  logic [31:0] memWdata, loadData;

  logic [31:0] ram    [16];
  logic [31:0] shadow [16];
  logic [31:0] lastLoad;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  word_lsu u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqSize(reqSize), .reqUnsigned(reqUnsigned), .baseVal(baseVal),
    .offsetImm(offsetImm), .storeData(storeData), .memRdata(memRdata),
    .memAddr(memAddr), .memWe(memWe), .memBe(memBe), .memWdata(memWdata),
    .misalign(misalign), .loadData(loadData), .loadValid(loadValid)
  );

  assign memRdata = ram[memAddr[3:0]];

  always @(posedge clk) begin
    if (memWe) begin
      for (int l = 0; l < 4; l++)
        if (memBe[l]) ram[memAddr[3:0]][l*8 +: 8] <= memWdata[l*8 +: 8];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] offAt(input int i);
    case (i)
      0: offAt = 16'h0000;
      1: offAt = 16'h0004;
      2: offAt = 16'hFFFC;
      3: offAt = 16'h0020;
      default: offAt = 16'hFFE0;
    endcase
  endfunction

  function automatic logic [31:0] expLoad(input logic [31:0] w, input int sz, input bit un);
    if (sz == 1) expLoad = un ? {16'h0, w[15:0]} : {{16{w[15]}}, w[15:0]};
    else if (sz == 2) expLoad = un ? {24'h0, w[7:0]} : {{24{w[7]}}, w[7:0]};
    else expLoad = w;
  endfunction

  task automatic doReq(input bit st, input int sz, input bit un,
                       input logic [31:0] base, input logic [15:0] off, input logic [31:0] sd);
    logic [31:0] ea, expW, expData;
    logic [3:0]  expBe;
    bit          mis;
    int          idx;
    @(negedge clk);
    chk(loadValid == 1'b0, "R8 idle valid", {31'b0, loadValid}, 32'h0);
    chk(loadData == lastLoad, "R8 idle hold", loadData, lastLoad);
    reqValid = 1'b1; reqStore = st; reqSize = sz[1:0]; reqUnsigned = un;
    baseVal = base; offsetImm = off; storeData = sd;
    #1;
    ea  = base + {{16{off[15]}}, off};
    mis = (ea[1:0] != 2'b00);
    idx = int'(ea[5:2]);
    chk(memAddr == ea[31:2], "R1 address", {2'b0, memAddr}, {2'b0, ea[31:2]});
    chk(misalign == mis, "R2 misalign", {31'b0, misalign}, {31'b0, mis});
    expBe = (sz == 1) ? 4'b0011 : (sz == 2) ? 4'b0001 : 4'b1111;
    if (!st || mis) expBe = 4'b0000;
    chk(memWe == (st && !mis), "R3 write strobe", {31'b0, memWe}, {31'b0, st && !mis});
    chk(memBe == expBe, (sz == 3) ? "R10 lanes" : "R4 lanes", {28'b0, memBe}, {28'b0, expBe});
    if (st && !mis) begin
      expW = '0;
      for (int l = 0; l < 4; l++)
        if (expBe[l]) begin
          expW[l*8 +: 8] = sd[l*8 +: 8];
          shadow[idx][l*8 +: 8] = sd[l*8 +: 8];
        end
      chk(memWdata == expW, "R4 write data", memWdata, expW);
    end
    @(negedge clk);
    if (!st && !mis) begin
      expData = expLoad(shadow[idx], sz, un);
      chk(loadValid == 1'b1, "R8 valid", {31'b0, loadValid}, 32'h1);
      chk(loadData == expData,
          (sz == 1) ? "R5 half load" : (sz == 2) ? "R6 byte load" : (sz == 3) ? "R10 load" : "R7 word load",
          loadData, expData);
      lastLoad = expData;
    end else begin
      chk(loadValid == 1'b0, "R3 no valid", {31'b0, loadValid}, 32'h0);
      chk(loadData == lastLoad, "R3 hold", loadData, lastLoad);
    end
    reqValid = 1'b0;
    #1;
    chk(!memWe && memBe == 4'b0000 && !misalign, "R11 idle outputs",
        {26'b0, memWe, memBe, misalign}, 32'h0);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    lastLoad = '0;
    for (int i = 0; i < 16; i++) begin
      ram[i]    = 32'h8F7E_A5C3 ^ (i * 32'h0102_0408);
      shadow[i] = 32'h8F7E_A5C3 ^ (i * 32'h0102_0408);
    end
    repeat (3) @(negedge clk);
    chk(loadValid == 1'b0 && loadData == 32'h0, "R9 reset", loadData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!memWe && !misalign && memBe == 4'b0000, "R11 after reset",
        {26'b0, memWe, memBe, misalign}, 32'h0);
    for (int lo = 0; lo < 4; lo++)
      for (int oi = 0; oi < 5; oi++)
        for (int sz = 0; sz < 4; sz++) begin
          doReq(1'b1, sz, 1'b0, 32'h1001_0000 + lo, offAt(oi),
                32'h80F1_C27E ^ ((lo * 20 + oi * 4 + sz) * 32'h1357_9BDF));
          for (int lz = 0; lz < 4; lz++)
            for (int un = 0; un < 2; un++)
              doReq(1'b0, lz, un[0], 32'h1001_0000 + lo, offAt(oi), 32'h0);
        end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule